// File: doc/BRIEF.md
# Multi-Mode 16-bit PWM Waveform Generator

This block is a 16-bit timer that counts either single-slope (up, then wrap to zero) or dual-slope (up to a limit, then back down). It drives two compare channels, A and B. A 4-bit mode input picks one of sixteen behaviours: free counting, clear-on-compare, fast PWM, phase-correct PWM or phase-and-frequency-correct PWM. The counting limit (TOP) comes from a fixed 8/9/10-bit value, from the 0xFFFF ceiling, from compare channel A, or from a separate limit input.

Each channel has a 2-bit output mode. It decides how the channel's waveform reacts to a compare match, to the count reaching TOP, and to the count direction. The block keeps sticky overflow and compare flags, and raises an interrupt request when a flag, its own enable and a global gate are all set. Per-channel force strobes apply the match action at once. Clock prescaling comes from outside through a count-enable input.

Top module: `pwm_wavegen`

## Requirements
- R1: Single-slope modes count up by one per enabled cycle and wrap to 0 after the cycle in which the count equals TOP. TOP is selected by mode:
  - 0: 0xFFFF.
  - 1 and 5: 0x00FF.
  - 2 and 6: 0x01FF.
  - 3 and 7: 0x03FF.
  - 4, 9, 11 and 15: the active compare A value.
  - 8, 10, 12 and 14: `cap_i`.
  - Modes 0, 4, 12, 5-7, 14 and 15 are single-slope.
- R2: The counter and all channel state change only in cycles where `cnt_en_i` is 1, except for force strobes and flag clears.
- R3: Dual-slope modes (1-3, 10, 11 phase-correct; 8, 9 phase-and-frequency-correct) count up to TOP and then down to 0. `dir_o` is 1 while counting down. The count visits TOP and 0 once per period.
- R4: In modes 0, 4 and 12 the output mode acts on a match as follows: 00 disconnects, 01 toggles, 10 clears, 11 sets.
- R5: In fast PWM, output mode 10 clears the waveform on a match and sets it at TOP. Output mode 11 sets it on a match and clears it at TOP. The TOP action wins if both occur in the same cycle.
- R6: In dual-slope modes, output mode 10 clears the waveform on a match while counting up and sets it on a match while counting down. Output mode 11 does the opposite.
- R7: In PWM modes, output mode 01 toggles channel A on a match only in modes 15, 9 and 11. In every other case both channels are disconnected.
  - A disconnected channel drives `wave_*_o` low.
  - A disconnected channel has `wave_oe_*_o` low.
- R8: In PWM modes each compare value is double-buffered and copied into use at TOP (fast and phase-correct) or at 0 (phase-and-frequency-correct). In modes 0, 4 and 12 the compare inputs take effect at once.
- R9: The overflow flag `flags_o[0]` sets on the wrap from TOP in single-slope modes and when the count is 0 in dual-slope modes.
- R10: The flags have a fixed layout and are cleared by write-1 on `flag_clr_i`:
  - `flags_o[1]` and `flags_o[2]` set on a counted compare match of A and B.
  - All flags are sticky until cleared through the matching bit of `flag_clr_i` (bit 0 overflow, 1 compare A, 2 compare B).
  - `irq_o` is `irq_gate_i` AND the OR of flags masked by `irq_en_i`.
- R11: A one-cycle `force_a_i`/`force_b_i` applies that channel's match action on the next edge, without counting and without setting a flag.
- R12: Mode 13 is reserved. The counter holds, both waveforms keep their value, force strobes are ignored and no flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable (prescaled tick) |
| mode_i | input | 4 | Operating mode 0-15 |
| om_a_i | input | 2 | Output mode channel A |
| om_b_i | input | 2 | Output mode channel B |
| cmp_a_i | input | 16 | Compare value A (buffer input) |
| cmp_b_i | input | 16 | Compare value B (buffer input) |
| cap_i | input | 16 | Limit value used as TOP in modes 8, 10, 12, 14 |
| force_a_i | input | 1 | Force compare strobe A |
| force_b_i | input | 1 | Force compare strobe B |
| flag_clr_i | input | 3 | Write-1 flag clear {B, A, ovf} |
| irq_en_i | input | 3 | Interrupt enables {B, A, ovf} |
| irq_gate_i | input | 1 | Global interrupt gate |
| cnt_o | output | 16 | Current count |
| dir_o | output | 1 | Count direction, 1 = down |
| wave_a_o | output | 1 | Waveform A |
| wave_b_o | output | 1 | Waveform B |
| wave_oe_a_o | output | 1 | Waveform A connected |
| wave_oe_b_o | output | 1 | Waveform B connected |
| flags_o | output | 3 | Sticky flags {cmp B, cmp A, ovf} |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the turn points of dual-slope counting, where a wrong direction bit would swap set and clear and shift every edge by a whole half-period. It checks that a compare value written mid-period is not used before TOP, or before 0 in phase-and-frequency-correct mode. A design that loaded it at once would clear the waveform at the new value in the same period. It also covers the first TOP after reset in mode 15, where TOP comes from the still-zero buffer, and the 0xFFFF wrap of free counting. Reserved mode 13, the channel-A-only toggle modes and force strobes that must not raise flags are checked at the pins, so a leaking update shows up as a changed waveform, count or flag.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [2:0] {
    GRP_NONPWM,
    GRP_FAST,
    GRP_PC,
    GRP_PFC,
    GRP_RSV
  } grp_e;

  typedef enum logic [1:0] {
    TOP_MAX,
    TOP_FIXED,
    TOP_CMPA,
    TOP_CAP
  } top_sel_e;

  typedef struct packed {
    grp_e       grp;
    top_sel_e   top_sel;
    logic [1:0] fix_bits;  // 0: 8-bit, 1: 9-bit, 2: 10-bit
    logic       tog_a;     // output mode 01 toggles channel A
  } mode_cfg_t;

  localparam logic [1:0] OM_DISC = 2'b00;
  localparam logic [1:0] OM_TOG  = 2'b01;
  localparam logic [1:0] OM_CLR  = 2'b10;
  localparam logic [1:0] OM_SET  = 2'b11;

  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    c = '{grp: GRP_NONPWM, top_sel: TOP_MAX, fix_bits: 2'd0, tog_a: 1'b0};
    case (m)
      4'd0:  c = '{GRP_NONPWM, TOP_MAX,   2'd0, 1'b0};
      4'd1:  c = '{GRP_PC,     TOP_FIXED, 2'd0, 1'b0};
      4'd2:  c = '{GRP_PC,     TOP_FIXED, 2'd1, 1'b0};
      4'd3:  c = '{GRP_PC,     TOP_FIXED, 2'd2, 1'b0};
      4'd4:  c = '{GRP_NONPWM, TOP_CMPA,  2'd0, 1'b0};
      4'd5:  c = '{GRP_FAST,   TOP_FIXED, 2'd0, 1'b0};
      4'd6:  c = '{GRP_FAST,   TOP_FIXED, 2'd1, 1'b0};
      4'd7:  c = '{GRP_FAST,   TOP_FIXED, 2'd2, 1'b0};
      4'd8:  c = '{GRP_PFC,    TOP_CAP,   2'd0, 1'b0};
      4'd9:  c = '{GRP_PFC,    TOP_CMPA,  2'd0, 1'b1};
      4'd10: c = '{GRP_PC,     TOP_CAP,   2'd0, 1'b0};
      4'd11: c = '{GRP_PC,     TOP_CMPA,  2'd0, 1'b1};
      4'd12: c = '{GRP_NONPWM, TOP_CAP,   2'd0, 1'b0};
      4'd13: c = '{GRP_RSV,    TOP_MAX,   2'd0, 1'b0};
      4'd14: c = '{GRP_FAST,   TOP_CAP,   2'd0, 1'b0};
      default: c = '{GRP_FAST, TOP_CMPA,  2'd0, 1'b1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwm_mode_dec.sv
module pwm_mode_dec
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [3:0]       mode_i,
  input  logic [CNT_W-1:0] cmp_a_act_i,
  input  logic [CNT_W-1:0] cap_i,
  output logic [CNT_W-1:0] top_o,
  output grp_e             grp_o,
  output logic             dual_o,
  output logic             pwm_o,
  output logic             upd_bot_o,
  output logic             tog_a_o
);
  localparam logic [CNT_W-1:0] TOP_8  = CNT_W'(10'h0FF);
  localparam logic [CNT_W-1:0] TOP_9  = CNT_W'(10'h1FF);
  localparam logic [CNT_W-1:0] TOP_10 = CNT_W'(10'h3FF);

  mode_cfg_t cfg;

  always_comb begin
    cfg = decode_mode(mode_i);
    case (cfg.top_sel)
      TOP_FIXED: top_o = (cfg.fix_bits == 2'd0) ? TOP_8 :
                         (cfg.fix_bits == 2'd1) ? TOP_9 : TOP_10;
      TOP_CMPA:  top_o = cmp_a_act_i;
      TOP_CAP:   top_o = cap_i;
      default:   top_o = '1;
    endcase
  end

  assign grp_o     = cfg.grp;
  assign dual_o    = (cfg.grp == GRP_PC) || (cfg.grp == GRP_PFC);
  assign pwm_o     = (cfg.grp == GRP_FAST) || dual_o;
  assign upd_bot_o = (cfg.grp == GRP_PFC);
  assign tog_a_o   = cfg.tog_a;

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             dual_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             top_evt_o,
  output logic             bot_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  logic             at_top;

  assign at_top    = (cnt_q >= top_i);
  assign top_evt_o = tick_i && at_top && !(dual_i && dir_q);
  assign bot_evt_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (tick_i) begin
      if (!dual_i) begin
        dir_q <= 1'b0;
        cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      end else if (top_i == '0) begin
        dir_q <= 1'b0;
        cnt_q <= '0;
      end else if (!dir_q) begin
        if (at_top) begin
          dir_q <= 1'b1;
          cnt_q <= top_i - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cnt_q == '0) begin
        dir_q <= 1'b0;
        cnt_q <= CNT_W'(1);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;

  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (cnt_q == $past(cnt_q)) && (dir_q == $past(dir_q)));

  assert_single_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !dual_i && at_top) |=> (cnt_q == '0));

  assert_dual_turn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && dual_i && !dir_q && at_top && top_i != '0) |=> dir_q);

endmodule

// File: rtl/pwm_cmp_buf.sv
module pwm_cmp_buf #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             pwm_i,
  input  logic             upd_i,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] buf_q;

  // tracks input while unbuffered so entering a PWM mode starts from the latest value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               buf_q <= '0;
    else if (!pwm_i || upd_i)  buf_q <= cmp_i;
  end

  assign act_o = pwm_i ? buf_q : cmp_i;

  assert_buf_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !upd_i) |=> (buf_q == $past(buf_q)));

endmodule

// File: rtl/pwm_out_ch.sv
module pwm_out_ch
  import pwm_pkg::*;
#(
  parameter bit IS_A = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  grp_e       grp_i,
  input  logic       tog_a_i,
  input  logic [1:0] om_i,
  input  logic       match_i,
  input  logic       top_evt_i,
  input  logic       dir_i,
  input  logic       force_i,
  output logic       wave_o,
  output logic       oe_o
);
  logic oc_q, oc_d, dual, is_pwm;

  assign dual   = (grp_i == GRP_PC) || (grp_i == GRP_PFC);
  assign is_pwm = dual || (grp_i == GRP_FAST);

  always_comb begin
    if (is_pwm && om_i == OM_TOG) oe_o = IS_A && tog_a_i;
    else                          oe_o = (om_i != OM_DISC);

    oc_d = oc_q;
    if (grp_i != GRP_RSV && oe_o) begin
      if (match_i || force_i)
        oc_d = (om_i == OM_TOG) ? ~oc_q : (om_i[0] ^ (dual & dir_i));
      // TOP action overrides a coincident match
      if (top_evt_i && grp_i == GRP_FAST && om_i[1])
        oc_d = ~om_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oc_q <= 1'b0;
    else         oc_q <= oc_d;
  end

  assign wave_o = oe_o & oc_q;

  assert_rsv_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_i == GRP_RSV) |=> (oc_q == $past(oc_q)));

  assert_fast_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_evt_i && grp_i == GRP_FAST && om_i == OM_CLR) |=> oc_q);

endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic [3:0]       mode_i,
  input  logic [1:0]       om_a_i,
  input  logic [1:0]       om_b_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic             force_a_i,
  input  logic             force_b_i,
  input  logic [2:0]       flag_clr_i,
  input  logic [2:0]       irq_en_i,
  input  logic             irq_gate_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             wave_a_o,
  output logic             wave_b_o,
  output logic             wave_oe_a_o,
  output logic             wave_oe_b_o,
  output logic [2:0]       flags_o,
  output logic             irq_o
);
  localparam int NCH = 2;

  logic [CNT_W-1:0] top, cnt;
  grp_e             grp;
  logic             dual, pwm, upd_bot, tog_a, tick, dir;
  logic             top_evt, bot_evt, ovf_evt, upd;
  logic [CNT_W-1:0] cmp_in  [NCH];
  logic [CNT_W-1:0] cmp_act [NCH];
  logic [1:0]       om      [NCH];
  logic [NCH-1:0]   frc, match, wave, oe;
  logic [2:0]       flags_q;

  assign cmp_in[0] = cmp_a_i;
  assign cmp_in[1] = cmp_b_i;
  assign om[0]     = om_a_i;
  assign om[1]     = om_b_i;
  assign frc       = {force_b_i, force_a_i};

  pwm_mode_dec #(.CNT_W(CNT_W)) i_dec (
    .mode_i      (mode_i),
    .cmp_a_act_i (cmp_act[0]),
    .cap_i       (cap_i),
    .top_o       (top),
    .grp_o       (grp),
    .dual_o      (dual),
    .pwm_o       (pwm),
    .upd_bot_o   (upd_bot),
    .tog_a_o     (tog_a)
  );

  assign tick = cnt_en_i && (grp != GRP_RSV);

  pwm_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .dual_i    (dual),
    .top_i     (top),
    .cnt_o     (cnt),
    .dir_o     (dir),
    .top_evt_o (top_evt),
    .bot_evt_o (bot_evt)
  );

  assign ovf_evt = dual ? bot_evt : top_evt;
  assign upd     = upd_bot ? bot_evt : top_evt;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_cmp_buf #(.CNT_W(CNT_W)) i_buf (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmp_i  (cmp_in[g]),
      .pwm_i  (pwm),
      .upd_i  (upd),
      .act_o  (cmp_act[g])
    );

    assign match[g] = tick && (cnt == cmp_act[g]);

    pwm_out_ch #(.IS_A(g == 0)) i_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .grp_i     (grp),
      .tog_a_i   (tog_a),
      .om_i      (om[g]),
      .match_i   (match[g]),
      .top_evt_i (top_evt),
      .dir_i     (dir),
      .force_i   (frc[g]),
      .wave_o    (wave[g]),
      .oe_o      (oe[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr_i) | {match[1], match[0], ovf_evt};
  end

  assign cnt_o       = cnt;
  assign dir_o       = dir;
  assign wave_a_o    = wave[0];
  assign wave_b_o    = wave[1];
  assign wave_oe_a_o = oe[0];
  assign wave_oe_b_o = oe[1];
  assign flags_o     = flags_q;
  assign irq_o       = irq_gate_i && |(flags_q & irq_en_i);

  assert_ovf_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> flags_q[0]);

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[1] && !flag_clr_i[1]) |=> flags_q[1]);

  assert_rsv_no_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp == GRP_RSV && flag_clr_i == 3'b000) |=> (flags_q == $past(flags_q)));

endmodule

// File: tb/test_pwm_wavegen.sv
module test_pwm_wavegen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en_i = 1'b0;
  logic [3:0]  mode_i = 4'd0;
  logic [1:0]  om_a_i = 2'b00, om_b_i = 2'b00;
  logic [15:0] cmp_a_i = '0, cmp_b_i = '0, cap_i = '0;
  logic        force_a_i = 1'b0, force_b_i = 1'b0;
  logic [2:0]  flag_clr_i = '0, irq_en_i = '0;
  logic        irq_gate_i = 1'b0;
  logic [15:0] cnt_o;
  logic        dir_o, wave_a_o, wave_b_o, wave_oe_a_o, wave_oe_b_o, irq_o;
  logic [2:0]  flags_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pwm_wavegen i_pwm_wavegen (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .mode_i(mode_i),
    .om_a_i(om_a_i), .om_b_i(om_b_i), .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i),
    .cap_i(cap_i), .force_a_i(force_a_i), .force_b_i(force_b_i),
    .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i), .irq_gate_i(irq_gate_i),
    .cnt_o(cnt_o), .dir_o(dir_o), .wave_a_o(wave_a_o), .wave_b_o(wave_b_o),
    .wave_oe_a_o(wave_oe_a_o), .wave_oe_b_o(wave_oe_b_o),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic tick(input int n);
    cnt_en_i = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en_i = 1'b0;
  endtask

  task automatic pulse_force(input bit a, input bit b);
    force_a_i = a; force_b_i = b;
    @(negedge clk);
    force_a_i = 1'b0; force_b_i = 1'b0;
  endtask

  task automatic t_reset();
    mode_i = 4'd0; om_a_i = 2'b11; om_b_i = 2'b11;
    do_reset();
    check("R1", "reset cnt", cnt_o, 0);
    check("R10", "reset flags", flags_o, 0);
    check("R4", "reset wave_a", wave_a_o, 0);
    check("R10", "reset irq", irq_o, 0);
  endtask

  task automatic t_enable_and_wrap();
    mode_i = 4'd0; om_a_i = 2'b00; om_b_i = 2'b00;
    do_reset();
    tick(5);
    check("R1", "normal count", cnt_o, 5);
    repeat (10) @(negedge clk);
    check("R2", "no enable hold", cnt_o, 5);
    tick(65530);
    check("R1", "normal at max", cnt_o, 16'hFFFF);
    check("R9", "no ovf before wrap", flags_o[0], 0);
    tick(1);
    check("R1", "normal wrap", cnt_o, 0);
    check("R9", "ovf on wrap", flags_o[0], 1);
  endtask

  task automatic t_fixed_tops();
    mode_i = 4'd5; do_reset();
    tick(255);
    check("R1", "mode5 at 0xFF", cnt_o, 16'h00FF);
    tick(1);
    check("R1", "mode5 wrap", cnt_o, 0);
    mode_i = 4'd7; do_reset();
    tick(1023);
    check("R1", "mode7 at 0x3FF", cnt_o, 16'h03FF);
    tick(1);
    check("R1", "mode7 wrap", cnt_o, 0);
  endtask

  task automatic t_ctc();
    mode_i = 4'd4; cmp_a_i = 16'd4; cmp_b_i = 16'd2; om_a_i = 2'b01; om_b_i = 2'b11;
    do_reset();
    tick(3);
    check("R4", "set B on match", wave_b_o, 1);
    check("R4", "A not yet", wave_a_o, 0);
    tick(2);
    check("R1", "ctc wrap at cmpA", cnt_o, 0);
    check("R4", "toggle A", wave_a_o, 1);
    check("R10", "cmpA flag", flags_o[1], 1);
    check("R9", "ovf on ctc wrap", flags_o[0], 1);
    tick(5);
    check("R4", "toggle A back", wave_a_o, 0);
    check("R4", "B stays set", wave_b_o, 1);
    om_b_i = 2'b10;
    tick(3);
    check("R4", "clear B on match", wave_b_o, 0);
  endtask

  task automatic t_fast();
    mode_i = 4'd14; cap_i = 16'd99; cmp_a_i = 16'd30; cmp_b_i = 16'd60;
    om_a_i = 2'b10; om_b_i = 2'b11;
    do_reset();
    tick(100);
    check("R5", "A set at TOP", wave_a_o, 1);
    check("R5", "B clear at TOP", wave_b_o, 0);
    check("R9", "fast ovf", flags_o[0], 1);
    tick(31);
    check("R5", "A clear on match", wave_a_o, 0);
    tick(30);
    check("R5", "B set on match", wave_b_o, 1);
    tick(39);
    check("R1", "fast wrap at cap", cnt_o, 0);
    check("R5", "A set again", wave_a_o, 1);
    check("R5", "B clear again", wave_b_o, 0);
  endtask

  task automatic t_fast_buffer();
    mode_i = 4'd14; cap_i = 16'd99; cmp_a_i = 16'd30; om_a_i = 2'b10; om_b_i = 2'b00;
    do_reset();
    tick(100);
    cmp_a_i = 16'd70;
    tick(31);
    check("R8", "old cmp used until TOP", wave_a_o, 0);
    tick(69);
    check("R8", "set at TOP", wave_a_o, 1);
    tick(70);
    check("R8", "new cmp not before 70", wave_a_o, 1);
    tick(1);
    check("R8", "new cmp after TOP", wave_a_o, 0);
  endtask

  task automatic t_phase_correct();
    mode_i = 4'd10; cap_i = 16'd20; cmp_a_i = 16'd5; cmp_b_i = 16'd15;
    om_a_i = 2'b10; om_b_i = 2'b11;
    do_reset();
    tick(21);
    check("R3", "turn at TOP cnt", cnt_o, 19);
    check("R3", "down after TOP", dir_o, 1);
    check("R6", "B set by up match at 0", wave_b_o, 1);
    flag_clr_i = 3'b111; @(negedge clk); flag_clr_i = 3'b000;
    check("R10", "flags cleared", flags_o, 0);
    tick(5);
    check("R6", "B clear on down match", wave_b_o, 0);
    tick(10);
    check("R6", "A set on down match", wave_a_o, 1);
    tick(4);
    check("R3", "at bottom", cnt_o, 0);
    check("R9", "no ovf before bottom", flags_o[0], 0);
    tick(1);
    check("R3", "up after bottom", dir_o, 0);
    check("R9", "ovf at bottom", flags_o[0], 1);
    tick(5);
    check("R6", "A clear on up match", wave_a_o, 0);
    tick(10);
    check("R6", "B set on up match", wave_b_o, 1);
  endtask

  task automatic t_pfc_buffer();
    mode_i = 4'd8; cap_i = 16'd20; cmp_a_i = 16'd5; om_a_i = 2'b10; om_b_i = 2'b00;
    do_reset();
    tick(25);
    cmp_a_i = 16'd10;
    tick(6);
    check("R8", "pfc keeps old cmp past TOP", wave_a_o, 0);
    tick(5);
    check("R8", "pfc old cmp down match", wave_a_o, 1);
    tick(14);
    check("R8", "pfc new cmp not yet", wave_a_o, 1);
    tick(1);
    check("R8", "pfc new cmp after bottom", wave_a_o, 0);
  endtask

  task automatic t_toggle_modes();
    mode_i = 4'd15; cmp_a_i = 16'd9; om_a_i = 2'b01; om_b_i = 2'b01;
    do_reset();
    check("R7", "mode15 A connected", wave_oe_a_o, 1);
    check("R7", "mode15 B disconnected", wave_oe_b_o, 0);
    tick(1);
    check("R7", "mode15 toggle at 0", wave_a_o, 1);
    tick(10);
    check("R7", "mode15 toggle at TOP", wave_a_o, 0);
    check("R1", "mode15 TOP from cmpA", cnt_o, 0);
    mode_i = 4'd14; @(negedge clk);
    check("R7", "mode14 A disconnected", wave_oe_a_o, 0);
    mode_i = 4'd10; @(negedge clk);
    check("R7", "mode10 A disconnected", wave_oe_a_o, 0);
    mode_i = 4'd11; @(negedge clk);
    check("R7", "mode11 A connected", wave_oe_a_o, 1);
    check("R7", "mode11 B disconnected", wave_oe_b_o, 0);
  endtask

  task automatic t_force();
    mode_i = 4'd0; om_a_i = 2'b11; om_b_i = 2'b01; cmp_a_i = 16'd100; cmp_b_i = 16'd100;
    do_reset();
    pulse_force(1'b1, 1'b1);
    check("R11", "force set A", wave_a_o, 1);
    check("R11", "force toggle B", wave_b_o, 1);
    check("R11", "force no flag", flags_o, 0);
    check("R11", "force no count", cnt_o, 0);
    pulse_force(1'b0, 1'b1);
    check("R11", "force toggle B back", wave_b_o, 0);
  endtask

  task automatic t_reserved();
    mode_i = 4'd0; om_a_i = 2'b11; om_b_i = 2'b00; cmp_a_i = 16'd100;
    do_reset();
    pulse_force(1'b1, 1'b0);
    mode_i = 4'd13; om_a_i = 2'b10; cmp_a_i = 16'd0;
    tick(10);
    pulse_force(1'b1, 1'b0);
    check("R12", "reserved count hold", cnt_o, 0);
    check("R12", "reserved wave hold", wave_a_o, 1);
    check("R12", "reserved no flag", flags_o, 0);
  endtask

  task automatic t_irq();
    mode_i = 4'd4; cmp_a_i = 16'd3; cmp_b_i = 16'd50; om_a_i = 2'b00; om_b_i = 2'b00;
    irq_en_i = 3'b010; irq_gate_i = 1'b0;
    do_reset();
    tick(4);
    check("R10", "cmpA flag", flags_o[1], 1);
    check("R10", "irq gated off", irq_o, 0);
    irq_gate_i = 1'b1; @(negedge clk);
    check("R10", "irq on", irq_o, 1);
    flag_clr_i = 3'b010; @(negedge clk); flag_clr_i = 3'b000;
    check("R10", "cmpA flag cleared", flags_o[1], 0);
    check("R10", "ovf flag kept", flags_o[0], 1);
    check("R10", "irq off after clear", irq_o, 0);
    irq_gate_i = 1'b0; irq_en_i = 3'b000;
  endtask

  initial begin
    t_reset();
    t_enable_and_wrap();
    t_fixed_tops();
    t_ctc();
    t_fast();
    t_fast_buffer();
    t_phase_correct();
    t_pfc_buffer();
    t_toggle_modes();
    t_force();
    t_reserved();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule